// File: doc/BRIEF.md
# Packed SIMD Lane Multiplier

This block is a two-stage pipelined multiplier for packed operands. Each operation carries two 128-bit operand vectors and a 3-bit mode code. The mode decides how the vectors split into lanes and how the lane products are combined. Five modes are defined:

- a four-lane 32-bit multiply;
- a sixteen-product 16-bit multiply, returned over two beats;
- a signed byte multiply that sums adjacent pairs;
- a complex 16-bit multiply built from four products per lane and combined by subtract and add;
- a carry-less byte multiply in GF(2^8), reduced by a parameterised polynomial.

Operations enter through a valid/ready handshake. Results leave on a 256-bit bus with a valid strobe. Every mode except the 16-bit mode takes one issue slot, so an operation can be accepted on every clock cycle. The 16-bit mode yields 512 bits of product. It therefore holds its operands for one extra cycle and emits two 256-bit beats back to back. A beat flag tells the two beats apart.

Top module: `simd_lane_mul`

## Requirements
- R1: An operation is accepted at a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high in every cycle except the one that follows the acceptance of a mode-1 operation, so all other modes accept one operation per cycle back to back.
- R2: The result of an operation accepted at rising edge N is presented with `out_valid` high, and with `out_beat` low for the first beat, from edge N+1 until edge N+2. Results leave in acceptance order.
- R3: Mode 0: operand bits [32i+31:32i] are signed 32-bit lanes, i = 0..3. Result bits [32i+31:32i] hold the low 32 bits of the product of lane i of A and lane i of B. Result bits [255:128] are zero.
- R4: Mode 1: operand bits [16k+15:16k] are signed 16-bit elements, k = 0..7. The first beat (`out_beat` = 0) holds A[k]*B[k] as a 32-bit value at bits [32k+31:32k]. The next cycle carries a second beat (`out_beat` = 1) holding A[k]*B[k^1] at the same positions.
- R5: Mode 2: operand bytes are signed. Result bits [32j+31:32j], j = 0..7, hold A[2j]*B[2j] + A[2j+1]*B[2j+1], sign-extended to 32 bits.
- R6: Mode 3: each 32-bit lane j is a complex value with the real part in its low 16 bits and the imaginary part in its high 16 bits, both signed. Result bits [64j+31:64j] hold the real part of A*B and bits [64j+63:64j+32] hold the imaginary part, each truncated to 32 bits.
- R7: Mode 4: result byte i (bits [8i+7:8i], i = 0..15) is the product of byte i of A and byte i of B in GF(2^8), reduced by x^8+x^4+x^3+x+1 (low byte 0x1B). For example 0x53 times 0xCA gives 0x01. Result bits [255:128] are zero.
- R8: Mode codes 5, 6 and 7 are accepted like any other operation and return an all-zero result with `out_valid` high.
- R9: After reset `out_valid` and `out_beat` are low, `out_data` is zero and `in_ready` is high.
- R10: `out_valid` is high only for the beats of an accepted operation. Cycles with `in_valid` low produce no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_mode | input | 3 | Operation mode code |
| in_a | input | 128 | Operand vector A |
| in_b | input | 128 | Operand vector B |
| out_valid | output | 1 | Result beat present |
| out_beat | output | 1 | High on the second beat of a mode-1 result |
| out_data | output | 256 | Result beat |

## Verification
The hardest situation to reach is a mode-1 operation whose second beat overlaps an operation already waiting at the input. In that case the one-cycle stall, the held operands and the next acceptance all meet in consecutive cycles. The bench reaches it by holding `in_valid` high across a mode-1 operation followed directly by a mode-0 operation. It checks that `in_ready` drops for exactly one cycle, that both beats arrive in order, and that the waiting operation's result follows straight after. Table vectors push each mode to its extreme lane values, such as the most negative times the most negative, wraparound in the complex sum, and the GF inverse pair.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;

  typedef enum logic [2:0] {
    MODE_MUL32  = 3'd0,
    MODE_MUL16  = 3'd1,
    MODE_DOT8   = 3'd2,
    MODE_CMUL16 = 3'd3,
    MODE_GF8    = 3'd4
  } op_mode_e;

  // Low 32 bits of a signed 32x32 product.
  function automatic logic [31:0] mul32_lo(input logic [31:0] x, input logic [31:0] y);
    logic signed [63:0] p;
    p = 64'($signed(x)) * 64'($signed(y));
    return p[31:0];
  endfunction

  // Full signed 16x16 product.
  function automatic logic [31:0] mul16_full(input logic [15:0] x, input logic [15:0] y);
    logic signed [31:0] p;
    p = 32'($signed(x)) * 32'($signed(y));
    return p;
  endfunction

  // Sum of two signed byte products.
  function automatic logic [31:0] dot8_pair(input logic [15:0] x, input logic [15:0] y);
    logic signed [31:0] lo_p;
    logic signed [31:0] hi_p;
    lo_p = 32'($signed(x[7:0]))  * 32'($signed(y[7:0]));
    hi_p = 32'($signed(x[15:8])) * 32'($signed(y[15:8]));
    return lo_p + hi_p;
  endfunction

  // Carry-less byte product followed by polynomial reduction.
  function automatic logic [7:0] gf8_mul(input logic [7:0] x, input logic [7:0] y,
                                         input logic [7:0] poly);
    logic [14:0] acc;
    acc = '0;
    for (int i = 0; i < 8; i++)
      if (y[i]) acc = acc ^ (15'(x) << i);
    for (int k = 14; k >= 8; k--)
      if (acc[k]) acc = acc ^ (15'({1'b1, poly}) << (k - 8));
    return acc[7:0];
  endfunction

endpackage

// File: rtl/simd_mul_issue.sv
module simd_mul_issue
  import simd_mul_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       in_mode,
  input  logic [VEC_W-1:0] in_a,
  input  logic [VEC_W-1:0] in_b,
  output logic             in_ready,
  output logic             accept,
  output logic             s1_valid,
  output logic [2:0]       s1_mode,
  output logic             s1_beat,
  output logic [VEC_W-1:0] s1_a,
  output logic [VEC_W-1:0] s1_b
);

  logic wide_pending;

  assign wide_pending = s1_valid && (s1_mode == MODE_MUL16) && !s1_beat;
  assign in_ready     = !wide_pending;
  assign accept       = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_beat  <= 1'b0;
      s1_mode  <= '0;
      s1_a     <= '0;
      s1_b     <= '0;
    end else if (wide_pending) begin
      s1_beat  <= 1'b1;
    end else if (accept) begin
      s1_valid <= 1'b1;
      s1_beat  <= 1'b0;
      s1_mode  <= in_mode;
      s1_a     <= in_a;
      s1_b     <= in_b;
    end else begin
      s1_valid <= 1'b0;
      s1_beat  <= 1'b0;
    end
  end

  // R1: a wide operation blocks the next issue slot
  p_wide_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_mode == MODE_MUL16) |=> !in_ready);

  // R1: the stall lasts exactly one cycle
  p_stall_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  // R4: operands stay put while the second beat is produced
  p_hold_ops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s1_beat |-> $stable(s1_a) && $stable(s1_b) && s1_valid);

endmodule

// File: rtl/simd_mul_lanes.sv
module simd_mul_lanes
  import simd_mul_pkg::*;
#(
  parameter int         VEC_W   = 128,
  parameter logic [7:0] GF_POLY = 8'h1B
) (
  input  logic [2:0]         mode,
  input  logic               beat,
  input  logic [VEC_W-1:0]   a,
  input  logic [VEC_W-1:0]   b,
  output logic [2*VEC_W-1:0] res
);

  localparam int N32   = VEC_W / 32;
  localparam int N16   = VEC_W / 16;
  localparam int N8    = VEC_W / 8;
  localparam int NDOT  = N8 / 2;
  localparam int OUT_W = 2 * VEC_W;

  logic [31:0] w32   [N32];
  logic [31:0] c_re  [N32];
  logic [31:0] c_im  [N32];
  logic [31:0] p_str [N16];
  logic [31:0] p_swp [N16];
  logic [31:0] d8    [NDOT];
  logic [7:0]  g8    [N8];

  for (genvar i = 0; i < N32; i++) begin : g_lane32
    logic [15:0] a_re, a_im, b_re, b_im;
    assign a_re    = a[32*i +: 16];
    assign a_im    = a[32*i+16 +: 16];
    assign b_re    = b[32*i +: 16];
    assign b_im    = b[32*i+16 +: 16];
    assign w32[i]  = mul32_lo(a[32*i +: 32], b[32*i +: 32]);
    assign c_re[i] = mul16_full(a_re, b_re) - mul16_full(a_im, b_im);
    assign c_im[i] = mul16_full(a_re, b_im) + mul16_full(a_im, b_re);
  end

  for (genvar k = 0; k < N16; k++) begin : g_lane16
    assign p_str[k] = mul16_full(a[16*k +: 16], b[16*k +: 16]);
    assign p_swp[k] = mul16_full(a[16*k +: 16], b[16*(k^1) +: 16]);
  end

  for (genvar j = 0; j < NDOT; j++) begin : g_dot
    assign d8[j] = dot8_pair(a[16*j +: 16], b[16*j +: 16]);
  end

  for (genvar m = 0; m < N8; m++) begin : g_gf
    assign g8[m] = gf8_mul(a[8*m +: 8], b[8*m +: 8], GF_POLY);
  end

  always_comb begin
    res = '0;
    case (mode)
      MODE_MUL32:  for (int i = 0; i < N32; i++) res[32*i +: 32] = w32[i];
      MODE_MUL16:  for (int k = 0; k < N16; k++) res[32*k +: 32] = beat ? p_swp[k] : p_str[k];
      MODE_DOT8:   for (int j = 0; j < NDOT; j++) res[32*j +: 32] = d8[j];
      MODE_CMUL16: for (int i = 0; i < N32; i++) res[64*i +: 64] = {c_im[i], c_re[i]};
      MODE_GF8:    for (int m = 0; m < N8; m++) res[8*m +: 8] = g8[m];
      default:     res = {OUT_W{1'b0}};
    endcase
  end

endmodule

// File: rtl/simd_mul_outreg.sv
module simd_mul_outreg
  import simd_mul_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s1_valid,
  input  logic [2:0]         s1_mode,
  input  logic               s1_beat,
  input  logic [2*VEC_W-1:0] res,
  output logic               out_valid,
  output logic               out_beat,
  output logic [2*VEC_W-1:0] out_data
);

  logic [2:0] out_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_beat  <= 1'b0;
      out_mode  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      out_beat  <= s1_valid && s1_beat;
      if (s1_valid) begin
        out_mode <= s1_mode;
        out_data <= res;
      end
    end
  end

  // R4: second beat only with a valid result
  p_beat_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_beat |-> out_valid && (out_mode == MODE_MUL16));

  // R4: second beat directly follows a first beat
  p_beat_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_beat |-> $past(out_valid) && !$past(out_beat));

  // R8: reserved codes give zero
  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_mode > 3'd4) |-> out_data == '0);

  // R3, R7: narrow modes leave the upper half clear
  p_upper_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ((out_mode == MODE_MUL32) || (out_mode == MODE_GF8))
      |-> out_data[2*VEC_W-1:VEC_W] == '0);

endmodule

// File: rtl/simd_lane_mul.sv
module simd_lane_mul
  import simd_mul_pkg::*;
#(
  parameter int         VEC_W   = 128,
  parameter logic [7:0] GF_POLY = 8'h1B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2:0]         in_mode,
  input  logic [VEC_W-1:0]   in_a,
  input  logic [VEC_W-1:0]   in_b,
  output logic               out_valid,
  output logic               out_beat,
  output logic [2*VEC_W-1:0] out_data
);

  localparam int OUT_W = 2 * VEC_W;

  logic             accept;
  logic             s1_valid;
  logic [2:0]       s1_mode;
  logic             s1_beat;
  logic [VEC_W-1:0] s1_a;
  logic [VEC_W-1:0] s1_b;
  logic [OUT_W-1:0] lane_res;

  simd_mul_issue #(.VEC_W(VEC_W)) u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_mode  (in_mode),
    .in_a     (in_a),
    .in_b     (in_b),
    .in_ready (in_ready),
    .accept   (accept),
    .s1_valid (s1_valid),
    .s1_mode  (s1_mode),
    .s1_beat  (s1_beat),
    .s1_a     (s1_a),
    .s1_b     (s1_b)
  );

  simd_mul_lanes #(.VEC_W(VEC_W), .GF_POLY(GF_POLY)) u_lanes (
    .mode (s1_mode),
    .beat (s1_beat),
    .a    (s1_a),
    .b    (s1_b),
    .res  (lane_res)
  );

  simd_mul_outreg #(.VEC_W(VEC_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_mode   (s1_mode),
    .s1_beat   (s1_beat),
    .res       (lane_res),
    .out_valid (out_valid),
    .out_beat  (out_beat),
    .out_data  (out_data)
  );

  // R2: fixed latency from acceptance to first beat
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 (out_valid && !out_beat));

  // R10: no first beat without an acceptance two edges earlier
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_beat |-> $past(accept, 2));

endmodule

// File: tb/simd_lane_mul_tb.sv
`timescale 1ns/1ps
module simd_lane_mul_tb;

  typedef struct packed {
    logic [2:0]   m;
    logic [127:0] a;
    logic [127:0] b;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t TBL [NVEC] = '{
    '{3'd0, 128'h7fffffff_80000000_fffffffe_00012345, 128'h00000002_ffffffff_fffffffd_00010000},
    '{3'd1, 128'h80007fff_ffff0001_1234fedc_00028000, 128'h80007fff_0003ffff_00100100_fff07fff},
    '{3'd2, 128'h80807f7f_01ff1020_3040c0d0_e0f00506, 128'h80807f81_ff01f0e0_d0c04030_20100708},
    '{3'd3, 128'h80008000_00010002_7fff8000_0003fffd, 128'h80008000_00040005_80007fff_fffe0007},
    '{3'd4, 128'h5302ff01_80ab1357_9bdf0011_22334455, 128'hca80ff01_02cd2468_ace00fff_eeddccbb},
    '{3'd5, 128'hffffffff_ffffffff_ffffffff_ffffffff, 128'hffffffff_ffffffff_ffffffff_ffffffff},
    '{3'd0, 128'hdeadbeef_12345678_00000000_ffffffff, 128'hcafef00d_87654321_55555555_ffffffff},
    '{3'd7, 128'h01234567_89abcdef_fedcba98_76543210, 128'h11111111_22222222_33333333_44444444}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   in_mode = '0;
  logic [127:0] in_a = '0;
  logic [127:0] in_b = '0;
  logic         out_valid;
  logic         out_beat;
  logic [255:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  simd_lane_mul u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_beat(out_beat), .out_data(out_data)
  );

  function automatic logic [7:0] gf_ref(input logic [7:0] x, input logic [7:0] y);
    logic [7:0] p;
    logic [7:0] xx;
    logic [7:0] yy;
    p = 8'h00; xx = x; yy = y;
    for (int n = 0; n < 8; n++) begin
      if (yy[0]) p = p ^ xx;
      xx = xx[7] ? ((xx << 1) ^ 8'h1B) : (xx << 1);
      yy = yy >> 1;
    end
    return p;
  endfunction

  function automatic logic [255:0] model(input vec_t v, input bit second);
    logic [255:0] r;
    r = '0;
    case (v.m)
      3'd0: for (int i = 0; i < 4; i++) begin
        longint x;
        x = longint'($signed(v.a[32*i +: 32])) * longint'($signed(v.b[32*i +: 32]));
        r[32*i +: 32] = x[31:0];
      end
      3'd1: for (int k = 0; k < 8; k++) begin
        int j;
        int p;
        j = second ? (k ^ 1) : k;
        p = int'($signed(v.a[16*k +: 16])) * int'($signed(v.b[16*j +: 16]));
        r[32*k +: 32] = p;
      end
      3'd2: for (int j = 0; j < 8; j++) begin
        int s;
        s = 0;
        for (int t = 0; t < 2; t++)
          s += int'($signed(v.a[8*(2*j+t) +: 8])) * int'($signed(v.b[8*(2*j+t) +: 8]));
        r[32*j +: 32] = s;
      end
      3'd3: for (int j = 0; j < 4; j++) begin
        longint ar, ai, br, bi, re, im;
        ar = longint'($signed(v.a[32*j +: 16]));
        ai = longint'($signed(v.a[32*j+16 +: 16]));
        br = longint'($signed(v.b[32*j +: 16]));
        bi = longint'($signed(v.b[32*j+16 +: 16]));
        re = ar * br - ai * bi;
        im = ar * bi + ai * br;
        r[64*j +: 32]    = re[31:0];
        r[64*j+32 +: 32] = im[31:0];
      end
      3'd4: for (int i = 0; i < 16; i++) r[8*i +: 8] = gf_ref(v.a[8*i +: 8], v.b[8*i +: 8]);
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid = 1'b1;
    in_mode  = v.m;
    in_a     = v.a;
    in_b     = v.b;
  endtask

  // Issue one operation from idle and check all of its beats.
  task automatic run_one(input vec_t v, input int idx);
    @(negedge clk);
    check(in_ready == 1'b1, "R1", 256'(in_ready), 256'(1));
    drive(v);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(out_valid && !out_beat, "R2", 256'({out_valid, out_beat}), 256'(2'b10));
    check(out_data == model(v, 1'b0), req_of(v.m), out_data, model(v, 1'b0));
    if (idx == 4)  // R7 inverse pair in the top byte
      check(out_data[127:120] == 8'h01, "R7", 256'(out_data[127:120]), 256'(8'h01));
    if (v.m == 3'd1) begin
      @(negedge clk);
      check(out_valid && out_beat, "R4", 256'({out_valid, out_beat}), 256'(2'b11));
      check(out_data == model(v, 1'b1), "R4", out_data, model(v, 1'b1));
    end
    @(negedge clk);
    check(!out_valid, "R10", 256'(out_valid), 256'(0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    check(!out_valid && !out_beat, "R9", 256'({out_valid, out_beat}), 256'(0));
    check(out_data == '0, "R9", out_data, '0);
    check(in_ready == 1'b1, "R9", 256'(in_ready), 256'(1));

    // R10 idle cycles give nothing
    repeat (3) @(negedge clk);
    check(!out_valid, "R10", 256'(out_valid), 256'(0));

    for (int idx = 0; idx < NVEC; idx++) run_one(TBL[idx], idx);

    // R1/R2 back to back single-slot operations, one per cycle
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        check(out_valid && !out_beat, "R2", 256'({out_valid, out_beat}), 256'(2'b10));
        check(out_data == model(TBL[(k-2)*2], 1'b0), "R2", out_data, model(TBL[(k-2)*2], 1'b0));
      end
      if (k < 3) begin
        check(in_ready == 1'b1, "R1", 256'(in_ready), 256'(1));
        drive(TBL[k*2]);
      end else begin
        in_valid = 1'b0;
      end
      @(posedge clk);
    end
    @(negedge clk);
    check(!out_valid, "R10", 256'(out_valid), 256'(0));

    // R1/R4 wide operation followed at once by a waiting mode-0 operation
    @(negedge clk);
    drive(TBL[1]);
    @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R1", 256'(in_ready), 256'(0));
    drive(TBL[6]);
    @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b1, "R1", 256'(in_ready), 256'(1));
    check(out_valid && !out_beat && out_data == model(TBL[1], 1'b0), "R4", out_data,
          model(TBL[1], 1'b0));
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_beat && out_data == model(TBL[1], 1'b1), "R4", out_data,
          model(TBL[1], 1'b1));
    @(posedge clk);
    @(negedge clk);
    check(out_valid && !out_beat && out_data == model(TBL[6], 1'b0), "R3", out_data,
          model(TBL[6], 1'b0));
    @(negedge clk);
    check(!out_valid, "R10", 256'(out_valid), 256'(0));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule